// File: doc/BRIEF.md
# SPI Command Slave with Event Line

This block is the host-facing command port of a small radio modem. An external controller talks to it over a four-wire SPI link in mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge, most significant bit first). Each frame is bounded by the active-low select. The first byte of a frame is an opcode. The opcode either writes block state (port direction, port output levels, a transmit payload buffer), requests an action (system reset, off mode, start of a frame transmission), or reads something back (port pins, status, an identifier, a registration code).

Every reply begins with a lead-in of two filler bytes. The slave shifts 0xFF while the opcode byte and the byte after it are exchanged. Reply data starts at byte index 2. Once the data is used up, filler bytes follow again. The lead-in gives the slave one full byte time to decode the opcode before its first data bit has to appear on MISO.

The block also drives an active-low event line toward the host. The line falls when any of these occurs:
- an internal completion strobe arrives (system ready, transmission done, measurement done, non-volatile write done);
- an opcode is rejected.

The line stays low until the host issues the status opcode. That opcode returns three status bytes taken at the moment of decode, and it clears them.

The controller is a state machine with these states:
- `ST_IDLE`: no frame is open.
- `ST_OPCODE`: waiting for the first byte.
- `ST_PARAM`: waiting for the single data byte of a port write.
- `ST_COUNT`: waiting for the payload byte count.
- `ST_PAYLOAD`: storing payload bytes.
- `ST_RESPOND`: streaming reply bytes.
- `ST_IGNORE`: discarding the rest of the frame.

Its transitions are:
- `ST_IDLE` goes to `ST_OPCODE` when select falls.
- `ST_OPCODE` goes to `ST_PARAM` for the two port writes.
- `ST_OPCODE` goes to `ST_COUNT` for the buffer load.
- `ST_OPCODE` goes to `ST_RESPOND` for the four reads.
- `ST_OPCODE` goes to `ST_IGNORE` for actions and rejected codes.
- `ST_PARAM` goes to `ST_IGNORE` after its byte.
- `ST_COUNT` goes to `ST_IGNORE` when the count is zero, and to `ST_PAYLOAD` otherwise.
- `ST_PAYLOAD` goes to `ST_IGNORE` after the last counted byte.
- Any state returns to `ST_IDLE` when select rises.

Top module: `spi_cmd_slave`

## Requirements
- R1: The SPI link works in mode 0, MSB first. A frame is bounded by `spi_nss_n` low. A byte of fewer than 8 bits left open when `spi_nss_n` rises is discarded and has no effect.
- R2: MISO carries 0xFF for byte indices 0 and 1 of every frame. It also carries 0xFF for any byte after a reply's data, and for every byte of a frame whose opcode is not a read.
- R3: Opcode 0x02 followed by one byte loads `port_dir_o` from the low PORT_W bits of that byte, with bit 0 always forced to 0. The reset value of `port_dir_o` is 0.
- R4: Opcode 0x03 followed by one byte loads `port_out_o` from the low PORT_W bits of that byte, with bit 0 always forced to 1. The reset value of `port_out_o` is 0x01.
- R5: Opcode 0x04 returns, at byte index 2, `port_in_i` zero-extended to 8 bits, with bit 0 always read as 1.
- R6: Opcode 0x07 is followed by a count byte N and then payload bytes.
  - The count byte empties the buffer and sets `txlen_o` to N. Any N above TXBUF_MAX is clamped to TXBUF_MAX.
  - The next `txlen_o` bytes are stored in order; payload byte k lands in `txbuf_o[8k+7:8k]`.
  - Further bytes in the same frame are ignored.
- R7: Opcode 0x0A returns three bytes at indices 2, 3 and 4:
  - index 2: `hw_stat_i`;
  - index 3: a firmware byte, with bit 6 = ready seen, bit 5 = frame sent, bits 4:1 = error code, bit 0 = `pa_on_i`, bit 7 = 0;
  - index 4: the last `lib_code_i` captured on `lib_vld_i`.
  The values returned are those present when the opcode byte completes.
- R8: `event_n_o` goes low the cycle after any of `rdy_evt_i`, `tx_done_i`, `meas_done_i`, `nvm_done_i`, or a rejected opcode. Completion of a 0x0A opcode byte drives `event_n_o` high and clears the ready flag, the sent flag, the error code and the library byte. A strobe in the same cycle as that clear wins over it.
- R9: Every opcode other than 0x01, 0x02, 0x03, 0x04, 0x05, 0x07, 0x0A, 0x0D, 0x0F and 0x12 is rejected. A rejected opcode sets error code 0001 and asserts the event line. All further bytes of that frame are ignored.
- R10: Opcode 0x0F returns 16 bytes from index 2. Byte j for j < 8 is `pac_i[8j+7:8j]`; bytes 8 to 15 are 0x00.
- R11: Opcode 0x12 returns 4 bytes from index 2, in the order ID[3], ID[2], ID[1], ID[0], where ID[k] = `dev_id_i[8k+7:8k]`.
- R12: Opcodes 0x01, 0x05 and 0x0D each raise exactly one one-cycle pulse on `sys_reset_o`, `off_mode_o` and `send_frame_o` respectively. No two of these pulses are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the SPI inputs are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | SPI data from the host |
| spi_nss_n | input | 1 | Active-low frame select |
| spi_miso | output | 1 | SPI data to the host |
| rdy_evt_i | input | 1 | Strobe: system ready after power-up or reset |
| tx_done_i | input | 1 | Strobe: frame transmission finished |
| meas_done_i | input | 1 | Strobe: supply/temperature measurement finished |
| nvm_done_i | input | 1 | Strobe: non-volatile write finished |
| lib_vld_i | input | 1 | Strobe: capture `lib_code_i` |
| lib_code_i | input | 8 | Protocol library status code |
| hw_stat_i | input | 8 | Hardware status byte |
| pa_on_i | input | 1 | Power amplifier on indication |
| port_in_i | input | PORT_W | Port pin levels |
| dev_id_i | input | 8*ID_BYTES | Device identifier |
| pac_i | input | 8*PAC_USED | Registration code, low bytes |
| event_n_o | output | 1 | Active-low event line |
| port_dir_o | output | PORT_W | Port direction register |
| port_out_o | output | PORT_W | Port output register |
| txbuf_o | output | 8*TXBUF_MAX | Transmit payload buffer |
| txlen_o | output | $clog2(TXBUF_MAX+1) | Payload byte count |
| sys_reset_o | output | 1 | One-cycle system reset request |
| off_mode_o | output | 1 | One-cycle off mode request |
| send_frame_o | output | 1 | One-cycle frame transmit request |

## Verification
The bench builds the block with its default parameters: PORT_W = 6, TXBUF_MAX = 12, ID_BYTES = 4, PAC_BYTES = 16 and PAC_USED = 8. With PORT_W = 6, all 64 direction, output and pin values can be swept. A buffer of 12 bytes lets every count from 0 to 15 be sent, covering the clamp and the bytes beyond it. After the sweep, a shorter load checks that a new count empties the buffer. All 256 opcode values are each sent once and followed by a status read, so every rejected code and every accepted one is checked against the error field and the event line.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_PARAM,
        ST_COUNT,
        ST_PAYLOAD,
        ST_RESPOND,
        ST_IGNORE
    } fsm_st_t;

    localparam logic [7:0] OP_SYSRST  = 8'h01;
    localparam logic [7:0] OP_SETDIR  = 8'h02;
    localparam logic [7:0] OP_SETOUT  = 8'h03;
    localparam logic [7:0] OP_GETPIN  = 8'h04;
    localparam logic [7:0] OP_OFF     = 8'h05;
    localparam logic [7:0] OP_LOADBUF = 8'h07;
    localparam logic [7:0] OP_STATUS  = 8'h0A;
    localparam logic [7:0] OP_SEND    = 8'h0D;
    localparam logic [7:0] OP_PAC     = 8'h0F;
    localparam logic [7:0] OP_ID      = 8'h12;

    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [3:0] ERR_BADCMD = 4'b0001;

endpackage

// File: rtl/spi_byte_link.sv
module spi_byte_link
    import spi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic       nss_n,
    input  logic [7:0] tx_next,
    output logic       frame_act,
    output logic       byte_vld,
    output logic [7:0] rx_byte,
    output logic       miso
);

    logic [2:0] sclk_q;
    logic [1:0] mosi_q;
    logic [1:0] nss_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       sclk_rise;
    logic       sclk_fall;

    assign sclk_rise = sclk_q[1] & ~sclk_q[2];
    assign sclk_fall = ~sclk_q[1] & sclk_q[2];
    assign frame_act = ~nss_q[1];
    assign miso      = tx_sh[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            mosi_q <= '0;
            nss_q  <= 2'b11;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            mosi_q <= {mosi_q[0], mosi};
            nss_q  <= {nss_q[0], nss_n};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= FILL_BYTE;
            byte_vld <= 1'b0;
            rx_byte  <= '0;
        end else if (!frame_act) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= FILL_BYTE;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= sclk_rise && (bit_cnt == 3'd7);
            if (sclk_rise) begin
                rx_sh   <= {rx_sh[5:0], mosi_q[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_byte <= {rx_sh, mosi_q[1]};
                end
            end
            if (byte_vld) begin
                tx_sh <= tx_next;
            end else if (sclk_fall && (bit_cnt != 3'd0)) begin
                tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spi_evt_status.sv
module spi_evt_status
    import spi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rdy_evt,
    input  logic       tx_done,
    input  logic       meas_done,
    input  logic       nvm_done,
    input  logic       bad_cmd,
    input  logic       stat_clr,
    input  logic       lib_vld,
    input  logic [7:0] lib_code,
    input  logic       pa_on,
    output logic [7:0] fw_stat,
    output logic [7:0] lib_stat,
    output logic       event_n
);

    logic       ready_f;
    logic       sent_f;
    logic [3:0] err_f;
    logic [7:0] lib_f;
    logic       pend_f;
    logic       any_set;

    assign any_set  = rdy_evt | tx_done | meas_done | nvm_done | bad_cmd;
    assign fw_stat  = {1'b0, ready_f, sent_f, err_f, pa_on};
    assign lib_stat = lib_f;
    assign event_n  = ~pend_f;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_f <= 1'b0;
            sent_f  <= 1'b0;
            err_f   <= '0;
            lib_f   <= '0;
            pend_f  <= 1'b0;
        end else begin
            if (rdy_evt)       ready_f <= 1'b1;
            else if (stat_clr) ready_f <= 1'b0;
            if (tx_done)       sent_f  <= 1'b1;
            else if (stat_clr) sent_f  <= 1'b0;
            if (bad_cmd)       err_f   <= ERR_BADCMD;
            else if (stat_clr) err_f   <= '0;
            if (lib_vld)       lib_f   <= lib_code;
            else if (stat_clr) lib_f   <= '0;
            if (any_set)       pend_f  <= 1'b1;
            else if (stat_clr) pend_f  <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_cmd_pkg::*;
#(
    parameter int PORT_W    = 6,
    parameter int TXBUF_MAX = 12,
    parameter int ID_BYTES  = 4,
    parameter int PAC_BYTES = 16,
    parameter int PAC_USED  = 8,
    localparam int LEN_W    = $clog2(TXBUF_MAX + 1),
    localparam int CNT_W    = $clog2(PAC_BYTES + 4)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_act,
    input  logic                     byte_vld,
    input  logic [7:0]               rx_byte,
    input  logic [PORT_W-1:0]        port_in,
    input  logic [7:0]               hw_stat,
    input  logic [7:0]               fw_stat,
    input  logic [7:0]               lib_stat,
    input  logic [8*ID_BYTES-1:0]    dev_id,
    input  logic [8*PAC_USED-1:0]    pac,
    output logic [7:0]               tx_next,
    output logic [PORT_W-1:0]        port_dir,
    output logic [PORT_W-1:0]        port_out,
    output logic [8*TXBUF_MAX-1:0]   txbuf,
    output logic [LEN_W-1:0]         txlen,
    output logic                     sys_reset,
    output logic                     off_mode,
    output logic                     send_frame,
    output logic                     bad_cmd,
    output logic                     stat_clr
);

    fsm_st_t            state, state_nx;
    logic [7:0]         cmd;
    logic [CNT_W-1:0]   rx_cnt;
    logic [CNT_W-1:0]   slot;
    logic [LEN_W-1:0]   pay_idx;
    logic [LEN_W-1:0]   cnt_cl;
    logic [7:0]         snap_hw, snap_fw, snap_lib;
    logic               opc_hit;
    logic               known;
    logic [8*PAC_USED-1:0] pac_sh;
    logic [8*ID_BYTES-1:0] id_sh;

    assign opc_hit  = byte_vld && (state == ST_OPCODE);
    assign stat_clr = opc_hit && (rx_byte == OP_STATUS);
    assign bad_cmd  = opc_hit && !known;
    assign slot     = rx_cnt - 1'b1;
    assign cnt_cl   = (rx_byte > 8'(TXBUF_MAX)) ? LEN_W'(TXBUF_MAX) : rx_byte[LEN_W-1:0];
    assign pac_sh   = pac >> {slot, 3'b000};
    assign id_sh    = dev_id >> (8 * (ID_BYTES - 1 - int'(slot)));

    always_comb begin
        case (rx_byte)
            OP_SYSRST, OP_SETDIR, OP_SETOUT, OP_GETPIN, OP_OFF,
            OP_LOADBUF, OP_STATUS, OP_SEND, OP_PAC, OP_ID: known = 1'b1;
            default: known = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!frame_act) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_OPCODE;
                ST_OPCODE: if (byte_vld) begin
                    case (rx_byte)
                        OP_SETDIR, OP_SETOUT:                  state_nx = ST_PARAM;
                        OP_LOADBUF:                            state_nx = ST_COUNT;
                        OP_GETPIN, OP_STATUS, OP_PAC, OP_ID:   state_nx = ST_RESPOND;
                        default:                               state_nx = ST_IGNORE;
                    endcase
                end
                ST_PARAM:   if (byte_vld) state_nx = ST_IGNORE;
                ST_COUNT:   if (byte_vld) state_nx = (cnt_cl == '0) ? ST_IGNORE : ST_PAYLOAD;
                ST_PAYLOAD: if (byte_vld && (pay_idx == txlen - 1'b1)) state_nx = ST_IGNORE;
                ST_RESPOND: state_nx = ST_RESPOND;
                ST_IGNORE:  state_nx = ST_IGNORE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_next = FILL_BYTE;
        if (state == ST_RESPOND && rx_cnt != '0) begin
            case (cmd)
                OP_GETPIN: if (slot == '0) tx_next = 8'({port_in[PORT_W-1:1], 1'b1});
                OP_STATUS: begin
                    if (int'(slot) == 0)      tx_next = snap_hw;
                    else if (int'(slot) == 1) tx_next = snap_fw;
                    else if (int'(slot) == 2) tx_next = snap_lib;
                end
                OP_PAC: if (int'(slot) < PAC_BYTES)
                    tx_next = (int'(slot) < PAC_USED) ? pac_sh[7:0] : 8'h00;
                OP_ID: if (int'(slot) < ID_BYTES) tx_next = id_sh[7:0];
                default: tx_next = FILL_BYTE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd        <= '0;
            rx_cnt     <= '0;
            pay_idx    <= '0;
            port_dir   <= '0;
            port_out   <= PORT_W'(1);
            txbuf      <= '0;
            txlen      <= '0;
            snap_hw    <= '0;
            snap_fw    <= '0;
            snap_lib   <= '0;
            sys_reset  <= 1'b0;
            off_mode   <= 1'b0;
            send_frame <= 1'b0;
        end else begin
            sys_reset  <= 1'b0;
            off_mode   <= 1'b0;
            send_frame <= 1'b0;
            if (!frame_act) begin
                rx_cnt <= '0;
            end else if (byte_vld) begin
                if (rx_cnt != '1) rx_cnt <= rx_cnt + 1'b1;
                case (state)
                    ST_OPCODE: begin
                        cmd <= rx_byte;
                        if (rx_byte == OP_SYSRST) sys_reset  <= 1'b1;
                        if (rx_byte == OP_OFF)    off_mode   <= 1'b1;
                        if (rx_byte == OP_SEND)   send_frame <= 1'b1;
                        if (rx_byte == OP_STATUS) begin
                            snap_hw  <= hw_stat;
                            snap_fw  <= fw_stat;
                            snap_lib <= lib_stat;
                        end
                    end
                    ST_PARAM: begin
                        if (cmd == OP_SETDIR) port_dir <= {rx_byte[PORT_W-1:1], 1'b0};
                        else                  port_out <= {rx_byte[PORT_W-1:1], 1'b1};
                    end
                    ST_COUNT: begin
                        txbuf   <= '0;
                        txlen   <= cnt_cl;
                        pay_idx <= '0;
                    end
                    ST_PAYLOAD: begin
                        txbuf[{pay_idx, 3'b000} +: 8] <= rx_byte;
                        pay_idx <= pay_idx + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int PORT_W    = 6,
    parameter int TXBUF_MAX = 12,
    parameter int ID_BYTES  = 4,
    parameter int PAC_BYTES = 16,
    parameter int PAC_USED  = 8,
    localparam int LEN_W    = $clog2(TXBUF_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     spi_sclk,
    input  logic                     spi_mosi,
    input  logic                     spi_nss_n,
    output logic                     spi_miso,
    input  logic                     rdy_evt_i,
    input  logic                     tx_done_i,
    input  logic                     meas_done_i,
    input  logic                     nvm_done_i,
    input  logic                     lib_vld_i,
    input  logic [7:0]               lib_code_i,
    input  logic [7:0]               hw_stat_i,
    input  logic                     pa_on_i,
    input  logic [PORT_W-1:0]        port_in_i,
    input  logic [8*ID_BYTES-1:0]    dev_id_i,
    input  logic [8*PAC_USED-1:0]    pac_i,
    output logic                     event_n_o,
    output logic [PORT_W-1:0]        port_dir_o,
    output logic [PORT_W-1:0]        port_out_o,
    output logic [8*TXBUF_MAX-1:0]   txbuf_o,
    output logic [LEN_W-1:0]         txlen_o,
    output logic                     sys_reset_o,
    output logic                     off_mode_o,
    output logic                     send_frame_o
);

    logic       frame_act;
    logic       byte_vld;
    logic [7:0] rx_byte;
    logic [7:0] tx_next;
    logic [7:0] fw_stat;
    logic [7:0] lib_stat;
    logic       bad_cmd;
    logic       stat_clr;

    spi_byte_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .nss_n     (spi_nss_n),
        .tx_next   (tx_next),
        .frame_act (frame_act),
        .byte_vld  (byte_vld),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    spi_cmd_fsm #(
        .PORT_W    (PORT_W),
        .TXBUF_MAX (TXBUF_MAX),
        .ID_BYTES  (ID_BYTES),
        .PAC_BYTES (PAC_BYTES),
        .PAC_USED  (PAC_USED)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_act  (frame_act),
        .byte_vld   (byte_vld),
        .rx_byte    (rx_byte),
        .port_in    (port_in_i),
        .hw_stat    (hw_stat_i),
        .fw_stat    (fw_stat),
        .lib_stat   (lib_stat),
        .dev_id     (dev_id_i),
        .pac        (pac_i),
        .tx_next    (tx_next),
        .port_dir   (port_dir_o),
        .port_out   (port_out_o),
        .txbuf      (txbuf_o),
        .txlen      (txlen_o),
        .sys_reset  (sys_reset_o),
        .off_mode   (off_mode_o),
        .send_frame (send_frame_o),
        .bad_cmd    (bad_cmd),
        .stat_clr   (stat_clr)
    );

    spi_evt_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy_evt   (rdy_evt_i),
        .tx_done   (tx_done_i),
        .meas_done (meas_done_i),
        .nvm_done  (nvm_done_i),
        .bad_cmd   (bad_cmd),
        .stat_clr  (stat_clr),
        .lib_vld   (lib_vld_i),
        .lib_code  (lib_code_i),
        .pa_on     (pa_on_i),
        .fw_stat   (fw_stat),
        .lib_stat  (lib_stat),
        .event_n   (event_n_o)
    );

endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
    parameter int PORT_W    = 6,
    parameter int TXBUF_MAX = 12,
    parameter int LEN_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_act,
    input logic              stat_clr,
    input logic              bad_cmd,
    input logic              rdy_evt_i,
    input logic              tx_done_i,
    input logic              meas_done_i,
    input logic              nvm_done_i,
    input logic              event_n_o,
    input logic              spi_miso,
    input logic [LEN_W-1:0]  txlen_o,
    input logic [PORT_W-1:0] port_dir_o,
    input logic [PORT_W-1:0] port_out_o,
    input logic              sys_reset_o,
    input logic              off_mode_o,
    input logic              send_frame_o
);

    // R8
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_evt_i || tx_done_i || meas_done_i || nvm_done_i) |=> !event_n_o);

    // R8
    evt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !(rdy_evt_i || tx_done_i || meas_done_i || nvm_done_i)) |=> event_n_o);

    // R9
    bad_cmd_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> !event_n_o);

    // R6
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txlen_o <= LEN_W'(TXBUF_MAX));

    // R3
    dir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> $stable(port_dir_o));

    // R4
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> $stable(port_out_o));

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_reset_o, off_mode_o, send_frame_o}));

    // R12
    send_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_frame_o |=> !send_frame_o);

    // R2
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> spi_miso);

endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(
    .PORT_W    (PORT_W),
    .TXBUF_MAX (TXBUF_MAX),
    .LEN_W     (LEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_act    (frame_act),
    .stat_clr     (stat_clr),
    .bad_cmd      (bad_cmd),
    .rdy_evt_i    (rdy_evt_i),
    .tx_done_i    (tx_done_i),
    .meas_done_i  (meas_done_i),
    .nvm_done_i   (nvm_done_i),
    .event_n_o    (event_n_o),
    .spi_miso     (spi_miso),
    .txlen_o      (txlen_o),
    .port_dir_o   (port_dir_o),
    .port_out_o   (port_out_o),
    .sys_reset_o  (sys_reset_o),
    .off_mode_o   (off_mode_o),
    .send_frame_o (send_frame_o)
);

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;

    localparam int PORT_W    = 6;
    localparam int TXBUF_MAX = 12;
    localparam int ID_BYTES  = 4;
    localparam int PAC_USED  = 8;
    localparam int LEN_W     = $clog2(TXBUF_MAX + 1);
    localparam int HALF      = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_mosi = 1'b0, spi_nss_n = 1'b1;
    logic spi_miso;
    logic rdy_evt_i = 0, tx_done_i = 0, meas_done_i = 0, nvm_done_i = 0, lib_vld_i = 0;
    logic [7:0] lib_code_i = '0;
    logic [7:0] hw_stat_i = '0;
    logic pa_on_i = 1'b0;
    logic [PORT_W-1:0] port_in_i = '0;
    logic [8*ID_BYTES-1:0] dev_id_i = 32'hC3A5_5A17;
    logic [8*PAC_USED-1:0] pac_i = 64'h0123_4567_89AB_CDEF;
    logic event_n_o;
    logic [PORT_W-1:0] port_dir_o, port_out_o;
    logic [8*TXBUF_MAX-1:0] txbuf_o;
    logic [LEN_W-1:0] txlen_o;
    logic sys_reset_o, off_mode_o, send_frame_o;

    int n_chk = 0, n_err = 0;
    int n_rst = 0, n_off = 0, n_send = 0;
    logic [7:0] mo_q [0:23];
    logic [7:0] mi_q [0:23];

    always #2 clk = ~clk;

    spi_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_nss_n(spi_nss_n), .spi_miso(spi_miso), .rdy_evt_i(rdy_evt_i),
        .tx_done_i(tx_done_i), .meas_done_i(meas_done_i), .nvm_done_i(nvm_done_i),
        .lib_vld_i(lib_vld_i), .lib_code_i(lib_code_i), .hw_stat_i(hw_stat_i),
        .pa_on_i(pa_on_i), .port_in_i(port_in_i), .dev_id_i(dev_id_i), .pac_i(pac_i),
        .event_n_o(event_n_o), .port_dir_o(port_dir_o), .port_out_o(port_out_o),
        .txbuf_o(txbuf_o), .txlen_o(txlen_o), .sys_reset_o(sys_reset_o),
        .off_mode_o(off_mode_o), .send_frame_o(send_frame_o)
    );

    always @(posedge clk) begin
        if (sys_reset_o)  n_rst++;
        if (off_mode_o)   n_off++;
        if (send_frame_o) n_send++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] mo, output logic [7:0] mi);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = mo[b];
            repeat (HALF) @(negedge clk);
            mi[b] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic run_frame(input int n);
        logic [7:0] got;
        spi_nss_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            xbyte(mo_q[i], got);
            mi_q[i] = got;
        end
        repeat (HALF) @(negedge clk);
        spi_nss_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic send1(input logic [7:0] a);
        mo_q[0] = a;
        run_frame(1);
    endtask

    task automatic send2(input logic [7:0] a, input logic [7:0] b);
        mo_q[0] = a; mo_q[1] = b;
        run_frame(2);
    endtask

    task automatic read_status();
        mo_q[0] = 8'h0A;
        for (int i = 1; i < 6; i++) mo_q[i] = 8'h00;
        run_frame(6);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: rdy_evt_i = 1'b1;
            1: tx_done_i = 1'b1;
            2: meas_done_i = 1'b1;
            default: nvm_done_i = 1'b1;
        endcase
        @(negedge clk);
        rdy_evt_i = 0; tx_done_i = 0; meas_done_i = 0; nvm_done_i = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int r, o, e;
        logic [7:0] exp_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // reset state (R4, R3, R8, R2)
        chk("R8 reset event", event_n_o, 1);
        chk("R3 reset dir", port_dir_o, 0);
        chk("R4 reset out", port_out_o, 1);
        chk("R6 reset len", txlen_o, 0);
        chk("R2 idle miso", spi_miso, 1);

        // R1: partial byte of a send opcode has no effect
        spi_nss_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 7; b >= 3; b--) begin
            spi_mosi = b[0];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        spi_nss_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 partial byte discarded", n_send, 0);
        send1(8'h0D);
        chk("R1 next frame aligned", n_send, 1);

        // R12: action pulses
        r = n_rst; o = n_off; e = n_send;
        send1(8'h01);
        chk("R12 sysreset pulse", n_rst, r + 1);
        send1(8'h05);
        chk("R12 off pulse", n_off, o + 1);
        send1(8'h0D);
        chk("R12 send pulse", n_send, e + 1);
        chk("R12 no extra sysreset", n_rst, r + 1);

        // R3 / R4: exhaustive port writes
        for (int v = 0; v < 64; v++) begin
            send2(8'h02, 8'(v) | 8'hC0);
            chk("R3 dir write", port_dir_o, 32'(v & 6'h3E));
            send2(8'h03, 8'(v));
            chk("R4 out write", port_out_o, 32'(v | 1));
        end

        // R5 / R2: exhaustive pin read
        for (int v = 0; v < 64; v++) begin
            port_in_i = 6'(v);
            for (int i = 0; i < 4; i++) mo_q[i] = (i == 0) ? 8'h04 : 8'h00;
            run_frame(4);
            chk("R2 lead byte0", mi_q[0], 8'hFF);
            chk("R2 lead byte1", mi_q[1], 8'hFF);
            chk("R5 pin read", mi_q[2], 32'(v | 1));
            chk("R2 trailing fill", mi_q[3], 8'hFF);
        end

        // R6: every count including above the limit
        for (int c = 0; c < 16; c++) begin
            int len;
            len = (c > TXBUF_MAX) ? TXBUF_MAX : c;
            mo_q[0] = 8'h07; mo_q[1] = 8'(c);
            for (int k = 0; k < c + 2; k++) mo_q[2 + k] = 8'(c * 16 + k + 1);
            run_frame(c + 4);
            chk("R6 length", txlen_o, 32'(len));
            for (int k = 0; k < TXBUF_MAX; k++) begin
                exp_b = (k < len) ? 8'(c * 16 + k + 1) : 8'h00;
                chk("R6 buffer byte", txbuf_o[8*k +: 8], exp_b);
            end
        end
        mo_q[0] = 8'h07; mo_q[1] = 8'd3; mo_q[2] = 8'hA1; mo_q[3] = 8'hA2; mo_q[4] = 8'hA3;
        run_frame(5);
        chk("R6 replace length", txlen_o, 3);
        chk("R6 replace clears", txbuf_o[8*TXBUF_MAX-1:24], 0);
        chk("R6 replace data", txbuf_o[23:0], 24'hA3A2A1);

        // R10: PAC read
        for (int i = 0; i < 20; i++) mo_q[i] = (i == 0) ? 8'h0F : 8'h00;
        run_frame(20);
        for (int j = 0; j < 16; j++) begin
            exp_b = (j < PAC_USED) ? pac_i[8*j +: 8] : 8'h00;
            chk("R10 pac byte", mi_q[2 + j], exp_b);
        end
        chk("R10 after pac fill", mi_q[18], 8'hFF);

        // R11: ID read
        for (int i = 0; i < 7; i++) mo_q[i] = (i == 0) ? 8'h12 : 8'h00;
        run_frame(7);
        for (int j = 0; j < 4; j++) chk("R11 id byte", mi_q[2 + j], dev_id_i[8*(3-j) +: 8]);
        chk("R11 after id fill", mi_q[6], 8'hFF);

        // R7 / R8: status and event line
        hw_stat_i = 8'h5A; pa_on_i = 1'b1;
        strobe(0);
        chk("R8 ready event low", event_n_o, 0);
        @(negedge clk); lib_code_i = 8'h0C; lib_vld_i = 1'b1;
        @(negedge clk); lib_vld_i = 1'b0;
        read_status();
        chk("R7 hw byte", mi_q[2], 8'h5A);
        chk("R7 fw byte ready", mi_q[3], 8'h41);
        chk("R7 lib byte", mi_q[4], 8'h0C);
        chk("R8 released", event_n_o, 1);
        read_status();
        chk("R7 fw cleared", mi_q[3], 8'h01);
        chk("R7 lib cleared", mi_q[4], 8'h00);
        strobe(1);
        chk("R8 txdone event", event_n_o, 0);
        read_status();
        chk("R7 sent bit", mi_q[3], 8'h21);
        strobe(2);
        chk("R8 meas event", event_n_o, 0);
        read_status();
        chk("R8 meas release", event_n_o, 1);
        strobe(3);
        chk("R8 nvm event", event_n_o, 0);
        read_status();
        chk("R8 nvm release", event_n_o, 1);
        pa_on_i = 1'b0; hw_stat_i = 8'h00;

        // R9: rejected opcode ignores following bytes
        send2(8'h03, 8'h15);
        mo_q[0] = 8'h0E; mo_q[1] = 8'h03; mo_q[2] = 8'h2A; mo_q[3] = 8'h05;
        o = n_off;
        run_frame(4);
        chk("R9 event on bad opcode", event_n_o, 0);
        chk("R9 trailing bytes ignored", port_out_o, 8'h15);
        chk("R9 no action", n_off, o);
        read_status();
        chk("R9 error code", mi_q[3], 8'h02);

        // R9: every opcode value
        for (int op = 0; op < 256; op++) begin
            bit ok;
            ok = (op == 8'h01) || (op == 8'h02) || (op == 8'h03) || (op == 8'h04) ||
                 (op == 8'h05) || (op == 8'h07) || (op == 8'h0A) || (op == 8'h0D) ||
                 (op == 8'h0F) || (op == 8'h12);
            send1(8'(op));
            chk("R9 sweep event", event_n_o, ok ? 1 : 0);
            read_status();
            chk("R9 sweep error field", mi_q[3], ok ? 8'h00 : 8'h02);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule